// File: doc/BRIEF.md
# Clock Control Register with Timer Prescaler and Clock-Out Divider

This block holds one 8-bit clock control register that a CPU reaches through a small special-function port at address 8Fh. The register sets two pieces of clock logic. The first is a reloading down counter. It produces a one-cycle tick enable that paces the timers and the watchdog elsewhere in the chip. The second is a power-of-two divider. When enabled, it drives a divided copy of the system clock toward an output pin.

The prescaler counts down from the programmed value to zero and then reloads, so its tick rate is the system clock divided by the field value plus one. A value of zero gives a tick on every cycle. A value of 11 gives the classic once-every-twelve-cycles rate. The clock-out divider is held in reset while it is disabled. Its waveform therefore always starts from the same phase when it is enabled. The timers, the watchdog, oscillator selection and pad control sit outside this block.

Top module: `clkctl_unit`

## Requirements
- R1: After reset the register reads 00h, the tick is high on every cycle, and the clock-out output is low.
- R2: A write with the address at 8Fh updates the register at that clock edge. A write to any other address leaves the register unchanged.
- R3: Bit 3 of the register always reads 0, and writing 1 to it has no effect.
- R4: Read data equals the register when the address is 8Fh, and is 00h for any other address.
- R5: With the prescaler field in bits 7:4 set to value P, the tick fires once every P+1 cycles (P=0 gives 1, P=11 gives 12, P=15 gives 16).
- R6: When P is greater than 0, each tick is high for exactly one cycle.
- R7: A new prescaler value takes effect at the first reload after the write edge. A write that lands on the same edge as a reload leaves that reload at the old value.
- R8: With the enable in bit 0 set and the divide field in bits 2:1 equal to S (00, 01, 10, 11), the clock-out output is a 50% duty square wave with a period of 2^(S+1) cycles (f/2, f/4, f/8, f/16).
- R9: While bit 0 is 0, the clock-out output stays low. In the first cycle after enabling, it is low. It first goes high 2^S cycles after the enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Special-function address for reads and writes |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, valid combinationally from the address |
| tick | output | 1 | One-cycle timer enable pulse |
| clkout | output | 1 | Divided clock for the output pin |

## Verification
A CPU write to the prescaler field and a prescaler reload can fall on the same clock edge. In that case it matters which value the reload takes. The bench sets P=3 and waits until it sees a tick, which marks the cycle in which the counter sits at zero. In that same cycle it issues a write of P=11. It then expects the next tick interval to be 4 cycles and the one after it to be 12. Shorter intervals would show that the count was truncated, and an interval of 12 right away would show that the reload picked up the new value too early.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned CC_DATA_W   = 8;
   localparam int unsigned CC_ADDR_W   = 8;
   localparam int unsigned CC_PRE_W    = 4;
   localparam int unsigned CC_DIVSEL_W = 2;
   localparam logic [7:0]  CC_REG_ADDR = 8'h8F;

   // Bit mask of the writable bits for a given field split.
   function automatic logic [CC_DATA_W-1:0] cc_write_mask(input int unsigned pre_w,
                                                          input int unsigned divsel_w);
      logic [CC_DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(CC_DATA_W); i++) begin
         if (i == 0) m[i] = 1'b1;
         else if (i <= int'(divsel_w)) m[i] = 1'b1;
         else if (i >= int'(CC_DATA_W) - int'(pre_w)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W   = CC_DATA_W,
   parameter int unsigned ADDR_W   = CC_ADDR_W,
   parameter int unsigned PRE_W    = CC_PRE_W,
   parameter int unsigned DIVSEL_W = CC_DIVSEL_W,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(CC_REG_ADDR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] cfg_q
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(cc_write_mask(PRE_W, DIVSEL_W));

   logic hit;
   assign hit = (addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr && hit) begin
         cfg_q <= wdata & WMASK;
      end
   end

   assign rdata = hit ? cfg_q : '0;
endmodule

// File: rtl/clkctl_prescaler.sv
module clkctl_prescaler #(
   parameter int unsigned PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] reload_val,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   // Reload samples the field only at zero, so a running count is never cut short.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (at_zero) begin
         cnt_q <= reload_val;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick = at_zero;
endmodule

// File: rtl/clkctl_clkout_div.sv
module clkctl_clkout_div #(
   parameter int unsigned DIVSEL_W   = 2,
   parameter bit          CLKOUT_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [DIVSEL_W-1:0] sel,
   output logic                clkout
);
   localparam int unsigned CNT_W = 1 << DIVSEL_W;

   logic [CNT_W-1:0] cnt_q;
   logic             tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tap = enable & cnt_q[sel];

   generate
      if (CLKOUT_REG) begin : g_reg_out
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= tap;
         end
         assign clkout = out_q;
      end else begin : g_comb_out
         assign clkout = tap;
      end
   endgenerate
endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W     = CC_DATA_W,
   parameter int unsigned ADDR_W     = CC_ADDR_W,
   parameter int unsigned PRE_W      = CC_PRE_W,
   parameter int unsigned DIVSEL_W   = CC_DIVSEL_W,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(CC_REG_ADDR),
   parameter bit          CLKOUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   output logic              tick,
   output logic              clkout
);
   localparam int unsigned PRE_LSB = DATA_W - PRE_W;

   generate
      if (PRE_W < 1 || DIVSEL_W < 1) begin : g_bad_widths
         $error("clkctl_unit: field widths must be at least 1");
      end
      if (PRE_W + DIVSEL_W + 1 > DATA_W) begin : g_bad_split
         $error("clkctl_unit: fields do not fit in the register");
      end
   endgenerate

   logic [DATA_W-1:0]   cfg_q;
   logic [PRE_W-1:0]    pre_sel;
   logic [DIVSEL_W-1:0] co_sel;
   logic                co_en;

   assign pre_sel = cfg_q[DATA_W-1:PRE_LSB];
   assign co_sel  = cfg_q[DIVSEL_W:1];
   assign co_en   = cfg_q[0];

   clkctl_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W),
      .DIVSEL_W(DIVSEL_W), .REG_ADDR(REG_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr(sfr_wr),
      .wdata(sfr_wdata), .rdata(sfr_rdata), .cfg_q(cfg_q)
   );

   clkctl_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .reload_val(pre_sel), .tick(tick)
   );

   clkctl_clkout_div #(.DIVSEL_W(DIVSEL_W), .CLKOUT_REG(CLKOUT_REG)) u_div (
      .clk(clk), .rst_n(rst_n), .enable(co_en), .sel(co_sel), .clkout(clkout)
   );
endmodule

// File: rtl/clkctl_unit_chk.sv
module clkctl_unit_chk
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W     = CC_DATA_W,
   parameter int unsigned ADDR_W     = CC_ADDR_W,
   parameter int unsigned PRE_W      = CC_PRE_W,
   parameter int unsigned DIVSEL_W   = CC_DIVSEL_W,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(CC_REG_ADDR),
   parameter bit          CLKOUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sfr_addr,
   input logic              sfr_wr,
   input logic [DATA_W-1:0] sfr_wdata,
   input logic [DATA_W-1:0] sfr_rdata,
   input logic              tick,
   input logic              clkout,
   input logic [DATA_W-1:0] cfg_q
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(cc_write_mask(PRE_W, DIVSEL_W));
   localparam int unsigned MAX_GAP = (1 << PRE_W) - 1;

   logic [PRE_W:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    gap_q <= '0;
      else if (tick) gap_q <= '0;
      else           gap_q <= gap_q + 1'b1;
   end

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && sfr_addr == REG_ADDR) |=> cfg_q == ($past(sfr_wdata) & WMASK));

   a_r2_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && sfr_addr != REG_ADDR) |=> $stable(cfg_q));

   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == REG_ADDR) |-> sfr_rdata[3] == 1'b0);

   a_r4_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr != REG_ADDR) |-> sfr_rdata == '0);

   a_r5_tick_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= (PRE_W+1)'(MAX_GAP));

   generate
      if (!CLKOUT_REG) begin : g_comb_checks
         a_r9_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_q[0] |-> !clkout);

         a_r8_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[0] && $past(cfg_q[0]) && cfg_q[DIVSEL_W:1] == '0
             && $past(cfg_q[DIVSEL_W:1]) == '0) |-> clkout != $past(clkout));
      end
   endgenerate
endmodule

bind clkctl_unit clkctl_unit_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W),
   .DIVSEL_W(DIVSEL_W), .REG_ADDR(REG_ADDR), .CLKOUT_REG(CLKOUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
   .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tick(tick),
   .clkout(clkout), .cfg_q(cfg_q)
);

// File: tb/clkctl_unit_tb_top.sv
module clkctl_unit_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [7:0] REG_A = 8'h8F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h00;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       tick;
   logic       clkout;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkctl_unit dut_i (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tick(tick), .clkout(clkout)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      cyc();
      sfr_wr = 1'b0; sfr_addr = REG_A;
   endtask

   task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
      sfr_addr = a;
      #1;
      d = sfr_rdata;
      sfr_addr = REG_A;
   endtask

   // Cycles until the next tick, starting from a sample point where tick is high.
   task automatic next_gap(output int n);
      n = 0;
      do begin
         cyc();
         n++;
      end while (!tick && n < 64);
   endtask

   task automatic sync_tick();
      int guard = 0;
      while (!tick && guard < 64) begin
         cyc();
         guard++;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      int ones = 0;
      read_reg(REG_A, d);
      check("R1 reset value", int'(d), 0);
      check("R1 clkout low", int'(clkout), 0);
      for (int i = 0; i < 5; i++) begin
         if (tick) ones++;
         cyc();
      end
      check("R1 tick every cycle", ones, 5);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      write_reg(REG_A, 8'hFF);
      read_reg(REG_A, d);
      check("R3 reserved bit reads 0", int'(d), 8'hF7);
      write_reg(8'h8E, 8'h00);
      read_reg(REG_A, d);
      check("R2 other address ignored", int'(d), 8'hF7);
      read_reg(8'h8E, d);
      check("R4 miss reads zero", int'(d), 0);
      write_reg(REG_A, 8'h5A);
      read_reg(REG_A, d);
      check("R2 write updates", int'(d), 8'h52);
      write_reg(REG_A, 8'h00);
   endtask

   task automatic t_prescale(input int p);
      int n;
      int high;
      write_reg(REG_A, 8'(p << 4));
      sync_tick();
      next_gap(n);
      next_gap(n);
      check($sformatf("R5 period for P=%0d", p), n, p + 1);
      if (p > 0) begin
         cyc();
         high = tick;
         check("R6 tick one cycle wide", high, 0);
      end
   endtask

   task automatic t_coincide();
      int n;
      write_reg(REG_A, 8'h30);
      sync_tick();
      next_gap(n);
      // Counter is at zero in this cycle; the write lands on the reload edge.
      write_reg(REG_A, 8'hB0);
      n = 1;
      while (!tick && n < 64) begin
         cyc();
         n++;
      end
      check("R7 reload keeps old value", n, 4);
      next_gap(n);
      check("R7 new value next reload", n, 12);
      write_reg(REG_A, 8'h00);
   endtask

   task automatic t_clkout(input int s);
      int bad = 0;
      int first_hi = -1;
      int per = 1 << (s + 1);
      write_reg(REG_A, 8'h00);
      for (int i = 0; i < 3; i++) begin
         if (clkout) bad++;
         cyc();
      end
      check("R9 low while disabled", bad, 0);
      bad = 0;
      write_reg(REG_A, 8'((s << 1) | 1));
      for (int i = 0; i < 2 * per; i++) begin
         if (int'(clkout) != ((i >> s) & 1)) bad++;
         if (clkout && first_hi < 0) first_hi = i;
         cyc();
      end
      check($sformatf("R8 waveform S=%0d", s), bad, 0);
      check($sformatf("R9 first high S=%0d", s), first_hi, 1 << s);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      sfr_addr = REG_A;
      t_reset();
      t_regs();
      t_prescale(0);
      t_prescale(11);
      t_prescale(15);
      t_prescale(2);
      t_coincide();
      for (int s = 0; s < 4; s++) t_clkout(s);
      write_reg(REG_A, 8'h00);
      cyc();
      check("R9 low after disable", int'(clkout), 0);
      done = 1'b1;
   end

   initial begin
      int cnt = 0;
      while (!done && cnt < 20000) begin
         @(posedge clk);
         cnt++;
      end
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      #2;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule